// File: doc/BRIEF.md
# Instruction Cache Block Stream Deserializer

This block sits behind a single-wire boot stream and turns it into whole instruction cache block records. Each record is 293 bits long: 256 payload bits followed by 37 control bits. The block gathers the bits of one record in a shift register. When the final bit arrives, it splits the record into its payload and control parts. The finished block is then offered on a valid/ready output, together with its block index and a flag that says whether the cache may commit it.

The control part carries tag, address-space-number and branch-history fields. It also carries two single-bit flags: valid and address-space-match. A block may be loaded only when both flags are set. A block with the valid flag clear is never reported as loadable, whatever its payload holds. A full boot load is 256 records, or 75008 bits. After the last record has been taken, the block raises a done flag and accepts no further input. While a finished block waits at the output, the serial input is held off.

Top module: `icb_deser`

## Requirements
- R1: After reset, `blk_vld` and `load_done` are 0 and `sin_rdy` is 1.
- R2: Payload bit k of `blk_data` (k = 0..255) equals the k-th bit accepted in the record, counting from 0, so the first bit lands in `blk_data[0]`.
- R3: Control bit j of `blk_ctrl` (j = 0..36) equals the (256+j)-th accepted bit of the record; tag and other control bits are passed through unchanged.
- R4: `blk_idx` is 0 for the first record after reset and rises by one for each following record, up to 255.
- R5: `blk_load` is 1 exactly when control bit 0 (valid) and control bit 1 (address-space-match) are both 1; a record with control bit 0 clear is never loadable.
- R6: While `blk_vld` is 1 and `blk_rdy` is 0, `blk_vld` stays 1 and `blk_data`, `blk_ctrl`, `blk_idx` and `blk_load` hold their values.
- R7: While a block is waiting at the output, `sin_rdy` is 0 and any bits offered on the serial input are ignored.
- R8: `load_done` rises together with `blk_vld` of the 256th record and stays 1; after that, `sin_rdy` stays 0 and no further block is produced.
- R9: Reset in the middle of a record discards the partial bits and restarts the block index at 0.
- R10: Cycles with `sin_vld` at 0 do not advance the record; bits may arrive with gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sin_vld | input | 1 | Serial bit is offered |
| sin_bit | input | 1 | Serial bit value |
| sin_rdy | output | 1 | Deserializer can take a bit this cycle |
| blk_vld | output | 1 | Completed block is presented |
| blk_rdy | input | 1 | Consumer takes the block |
| blk_data | output | 256 | Payload bits of the block |
| blk_ctrl | output | 37 | Control bits of the block |
| blk_idx | output | 8 | Index of the presented block |
| blk_load | output | 1 | Block may be committed (valid and address-space-match set) |
| load_done | output | 1 | All 256 records have been received |

## Verification
The assertions assume the producer honours `sin_rdy`. They also assume a bit counts only in a cycle where both `sin_vld` and `sin_rdy` are high, so a record is never completed while the output is still occupied. The bench's bit-sending task waits for `sin_rdy` before it raises `sin_vld`. The only times it offers bits against a low `sin_rdy` are the stall and post-done scenarios. Those scenarios deliberately probe whether offered bits are dropped, and correct design behaviour keeps every assertion satisfied there.

// File: rtl/icb_pkg.sv
package icb_pkg;
    localparam int DEF_DATA_W  = 256;
    localparam int DEF_CTRL_W  = 37;
    localparam int DEF_NUM_BLK = 256;
    localparam int DEF_V_POS   = 0;
    localparam int DEF_ASM_POS = 1;
endpackage

// File: rtl/icb_bit_gather.sv
module icb_bit_gather #(
    parameter int DATA_W = icb_pkg::DEF_DATA_W,
    parameter int CTRL_W = icb_pkg::DEF_CTRL_W,
    localparam int REC_W = DATA_W + CTRL_W,
    localparam int CNT_W = $clog2(REC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             accept,
    output logic             rec_done,
    output logic [REC_W-1:0] rec_word
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_W - 1);

    typedef struct packed {
        logic [REC_W-2:0] sh;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic take;

    always_comb begin
        st_d     = st_q;
        take     = bit_vld && accept;
        rec_done = take && (st_q.cnt == LAST);
        rec_word = {bit_val, st_q.sh};
        if (take) begin
            st_d.sh  = {bit_val, st_q.sh[REC_W-2:1]};
            st_d.cnt = rec_done ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R2
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(st_q.cnt)); // R10
endmodule

// File: rtl/icb_blk_hold.sv
module icb_blk_hold #(
    parameter int DATA_W  = icb_pkg::DEF_DATA_W,
    parameter int CTRL_W  = icb_pkg::DEF_CTRL_W,
    parameter int NUM_BLK = icb_pkg::DEF_NUM_BLK,
    parameter int V_POS   = icb_pkg::DEF_V_POS,
    parameter int ASM_POS = icb_pkg::DEF_ASM_POS,
    localparam int REC_W  = DATA_W + CTRL_W,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [REC_W-1:0]  rec_word,
    input  logic              out_rdy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic [BLK_W-1:0]  out_idx,
    output logic              out_load,
    output logic              done
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLK - 1);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [CTRL_W-1:0] ctrl;
        logic              load;
        logic [BLK_W-1:0]  idx;
        logic [BLK_W-1:0]  cnt;
        logic              done;
    } st_t;

    st_t st_d, st_q;
    logic [CTRL_W-1:0] new_ctrl;

    always_comb begin
        st_d     = st_q;
        new_ctrl = rec_word[REC_W-1:DATA_W];
        if (st_q.vld && out_rdy) st_d.vld = 1'b0;
        if (cap) begin
            st_d.vld  = 1'b1;
            st_d.data = rec_word[DATA_W-1:0];
            st_d.ctrl = new_ctrl;
            st_d.load = new_ctrl[V_POS] && new_ctrl[ASM_POS];
            st_d.idx  = st_q.cnt;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BLK) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_data = st_q.data;
    assign out_ctrl = st_q.ctrl;
    assign out_idx  = st_q.idx;
    assign out_load = st_q.load;
    assign done     = st_q.done;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld && !out_rdy |=> st_q.vld && $stable(st_q.data) && $stable(st_q.idx)); // R6
    AST_NO_CAP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> !st_q.vld); // R7
    AST_LOAD_NEEDS_V: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |-> st_q.ctrl[V_POS] && st_q.ctrl[ASM_POS]); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done); // R8
    AST_NO_CAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !cap); // R8
endmodule

// File: rtl/icb_deser.sv
module icb_deser #(
    parameter int DATA_W  = icb_pkg::DEF_DATA_W,
    parameter int CTRL_W  = icb_pkg::DEF_CTRL_W,
    parameter int NUM_BLK = icb_pkg::DEF_NUM_BLK,
    parameter int V_POS   = icb_pkg::DEF_V_POS,
    parameter int ASM_POS = icb_pkg::DEF_ASM_POS,
    localparam int REC_W  = DATA_W + CTRL_W,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sin_vld,
    input  logic              sin_bit,
    output logic              sin_rdy,
    output logic              blk_vld,
    input  logic              blk_rdy,
    output logic [DATA_W-1:0] blk_data,
    output logic [CTRL_W-1:0] blk_ctrl,
    output logic [BLK_W-1:0]  blk_idx,
    output logic              blk_load,
    output logic              load_done
);
    logic             rec_done;
    logic [REC_W-1:0] rec_word;

    assign sin_rdy = !blk_vld && !load_done;

    icb_bit_gather #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (sin_vld),
        .bit_val  (sin_bit),
        .accept   (sin_rdy),
        .rec_done (rec_done),
        .rec_word (rec_word)
    );

    icb_blk_hold #(
        .DATA_W(DATA_W), .CTRL_W(CTRL_W), .NUM_BLK(NUM_BLK),
        .V_POS(V_POS), .ASM_POS(ASM_POS)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (rec_done),
        .rec_word (rec_word),
        .out_rdy  (blk_rdy),
        .out_vld  (blk_vld),
        .out_data (blk_data),
        .out_ctrl (blk_ctrl),
        .out_idx  (blk_idx),
        .out_load (blk_load),
        .done     (load_done)
    );
endmodule

// File: tb/sim_icb_deser.sv
module sim_icb_deser;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sin_vld = 1'b0;
    logic         sin_bit = 1'b0;
    logic         sin_rdy;
    logic         blk_vld;
    logic         blk_rdy = 1'b0;
    logic [255:0] blk_data;
    logic [36:0]  blk_ctrl;
    logic [7:0]   blk_idx;
    logic         blk_load;
    logic         load_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    icb_deser u0 (
        .clk(clk), .rst_n(rst_n), .sin_vld(sin_vld), .sin_bit(sin_bit),
        .sin_rdy(sin_rdy), .blk_vld(blk_vld), .blk_rdy(blk_rdy),
        .blk_data(blk_data), .blk_ctrl(blk_ctrl), .blk_idx(blk_idx),
        .blk_load(blk_load), .load_done(load_done)
    );

    task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_data(int b);
        logic [255:0] d;
        for (int k = 0; k < 8; k++) begin
            d[k*32 +: 32] = {8'(b) ^ 8'(k), ~8'(b), 16'hC35A ^ 16'(b*31 + k)};
        end
        return d;
    endfunction

    function automatic logic [36:0] mk_ctrl(int b);
        logic [36:0] c;
        c = {5'(b), 32'(b * 32'h9E37_79B9)};
        c[0] = b[0];
        c[1] = b[1];
        return c;
    endfunction

    task automatic send_bit(logic v, int gap);
        @(negedge clk);
        while (!sin_rdy) @(negedge clk);
        sin_vld = 1'b1;
        sin_bit = v;
        @(posedge clk);
        #1 sin_vld = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    task automatic send_block(int b, int gap);
        logic [292:0] rec;
        rec = {mk_ctrl(b), mk_data(b)};
        for (int i = 0; i < 293; i++) send_bit(rec[i], gap);
    endtask

    task automatic recv_block(int b);
        @(negedge clk);
        while (!blk_vld) @(negedge clk);
        chk(blk_data == mk_data(b), "R2", blk_data, mk_data(b));
        chk(blk_ctrl == mk_ctrl(b), "R3", 256'(blk_ctrl), 256'(mk_ctrl(b)));
        chk(blk_idx == 8'(b), "R4", 256'(blk_idx), 256'(b));
        chk(blk_load == (b[0] && b[1]), "R5", 256'(blk_load), 256'(b[0] && b[1]));
        if (b != 255) chk(load_done == 1'b0, "R8", 256'(load_done), 256'(0));
        else          chk(load_done == 1'b1, "R8", 256'(load_done), 256'(1));
        blk_rdy = 1'b1;
        @(posedge clk);
        #1 blk_rdy = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(blk_vld == 1'b0, "R1", 256'(blk_vld), 256'(0));
        chk(load_done == 1'b0, "R1", 256'(load_done), 256'(0));
        chk(sin_rdy == 1'b1, "R1", 256'(sin_rdy), 256'(1));
    endtask

    task automatic test_mid_reset();
        for (int i = 0; i < 100; i++) send_bit(1'b1, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(blk_vld == 1'b0, "R9", 256'(blk_vld), 256'(0));
    endtask

    task automatic test_stall(int b);
        send_block(b, 0);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            sin_vld = 1'b1;
            sin_bit = i[0];
            @(negedge clk);
            chk(blk_vld == 1'b1, "R6", 256'(blk_vld), 256'(1));
            chk(blk_data == mk_data(b), "R6", blk_data, mk_data(b));
            chk(sin_rdy == 1'b0, "R7", 256'(sin_rdy), 256'(0));
        end
        sin_vld = 1'b0;
        recv_block(b);
    endtask

    task automatic test_after_done();
        int seen = 0;
        @(negedge clk);
        chk(load_done == 1'b1, "R8", 256'(load_done), 256'(1));
        sin_vld = 1'b1;
        for (int i = 0; i < 400; i++) begin
            sin_bit = i[1];
            @(negedge clk);
            if (blk_vld || sin_rdy) seen++;
        end
        sin_vld = 1'b0;
        chk(seen == 0, "R8", 256'(seen), 256'(0));
        chk(load_done == 1'b1, "R8", 256'(load_done), 256'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_mid_reset();
        for (int b = 0; b < 256; b++) begin
            if (b == 3) test_stall(b);
            else begin
                send_block(b, (b == 5) ? 2 : 0); // R10 gaps on block 5
                recv_block(b);
            end
        end
        test_after_done();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule